// File: doc/BRIEF.md
# Register-Indexed Clock Source Selector

This block models one clock-source multiplexer in a clock tree that works with frequency values rather than with clock edges. It holds a 32-bit select register that it shares with its sibling selectors. Every sibling sees the same write port, and each one decodes its own bit field from that word. The decoded field picks one of up to five 64-bit input frequency values, and the block drives the chosen value on its output.

Three parameters describe an instance: the position of the field, the width of the field, and the number of valid inputs. A single module therefore covers a 5-input selector with a 3-bit field at bit 18, a 4-input selector with a 2-bit field at bit 0, or a 2-input selector with a 1-bit field at bit 5.

A field code that names no existing input does not produce an undefined result. The selector falls back to input 0 and raises a one-cycle fault pulse, so that a monitor can report the bad programming. The output is registered. It follows a register write, or any change of an input frequency, one clock edge later.

Top module: `clk_src_select`

## Requirements
- R1: While `rst_n` is low, `freq_out` is 0 and `sel_fault` is 0, and the select register takes the value `RESET_SEL`. After the first rising edge with `rst_n` high, `freq_out` equals the input that the field of `RESET_SEL` names.
- R2: A write (`sel_wr_en` high at a rising edge) with field code k = `sel_wr_data[FIELD_LSB+FIELD_W-1:FIELD_LSB]` and k < `NUM_INPUTS` makes `freq_out` equal `freq_in[k]` from that edge onward.
- R3: A write with field code k >= `NUM_INPUTS` makes `freq_out` equal `freq_in[0]`, and sets `sel_fault` to 1 for the one cycle after that edge.
- R4: `sel_fault` is 0 in every cycle that does not directly follow an out-of-range write. This includes idle cycles in which the register still holds an out-of-range code.
- R5: Bits of `sel_wr_data` outside the selector's field do not affect `freq_out` or `sel_fault`.
- R6: With no write, a change of any input frequency reaches `freq_out` one edge later for the selected input. This also applies to input 0 while an out-of-range code is held.
- R7: With `sel_wr_en` low, the select register keeps its value, so the selected input does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_wr_en | input | 1 | Write strobe for the shared select register |
| sel_wr_data | input | 32 | Value written to the select register |
| freq_in | input | NUM_INPUTS x 64 | Candidate input frequencies, entry i is input i |
| freq_out | output | 64 | Selected frequency (registered) |
| sel_fault | output | 1 | One-cycle pulse after an out-of-range write |

## Verification
The field is driven with every in-range code in turn. This separates a correct index decode from one that has the field shifted or truncated. The three codes past the last input are also written, to show the fallback to input 0 and the fault pulse, and idle cycles follow to confirm that the fault is a pulse and not a level.

Two writes carry the same field with every bit outside it flipped, which exposes any decode that reads the wrong bits. Input values then change under a held select, both in range and out of range, to show that input changes propagate without a write. A long stretch of random writes and input changes is compared against a behavioural model on every clock.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
    localparam int unsigned CSEL_REG_W     = 32;
    localparam int unsigned CSEL_FREQ_W    = 64;
    localparam int unsigned CSEL_MAX_INPUT = 5;

    typedef struct packed {
        logic [CSEL_REG_W-1:0]  sel;
        logic [CSEL_FREQ_W-1:0] freq;
        logic                   fault;
    } csel_state_t;
endpackage

// File: rtl/clk_sel_field_decode.sv
module clk_sel_field_decode #(
    parameter int unsigned REG_W      = 32,
    parameter int unsigned FIELD_LSB  = 18,
    parameter int unsigned FIELD_W    = 3,
    parameter int unsigned NUM_INPUTS = 5,
    localparam int unsigned IDX_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
    input  logic [REG_W-1:0] reg_val,
    output logic [IDX_W-1:0] use_idx,
    output logic             bad_code
);
    logic [FIELD_W-1:0] raw;
    logic [31:0]        raw_ext;

    always_comb begin
        raw      = reg_val[FIELD_LSB +: FIELD_W];
        raw_ext  = 32'(raw);
        bad_code = (raw_ext >= NUM_INPUTS);
        use_idx  = bad_code ? '0 : raw_ext[IDX_W-1:0];
    end
endmodule

// File: rtl/clk_sel_freq_mux.sv
module clk_sel_freq_mux #(
    parameter int unsigned NUM_INPUTS = 5,
    parameter int unsigned FREQ_W     = 64,
    localparam int unsigned IDX_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
    input  logic [NUM_INPUTS-1:0][FREQ_W-1:0] freq_in,
    input  logic [IDX_W-1:0]                  idx,
    output logic [FREQ_W-1:0]                 freq_sel
);
    logic [NUM_INPUTS-1:0][FREQ_W-1:0] masked;

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_term
        assign masked[i] = freq_in[i] & {FREQ_W{idx == IDX_W'(i)}};
    end

    always_comb begin
        freq_sel = '0;
        for (int i = 0; i < NUM_INPUTS; i++) begin
            freq_sel = freq_sel | masked[i];
        end
    end
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
    import clk_sel_pkg::*;
#(
    parameter int unsigned NUM_INPUTS = 5,
    parameter int unsigned FIELD_LSB  = 18,
    parameter int unsigned FIELD_W    = 3,
    parameter logic [31:0] RESET_SEL  = 32'h0008_0000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   sel_wr_en,
    input  logic [31:0]                            sel_wr_data,
    input  logic [NUM_INPUTS-1:0][CSEL_FREQ_W-1:0] freq_in,
    output logic [CSEL_FREQ_W-1:0]                 freq_out,
    output logic                                   sel_fault
);
    localparam int unsigned IDX_W = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1;

    csel_state_t            st_d, st_q;
    logic [IDX_W-1:0]       use_idx_d;
    logic                   bad_code_d;
    logic [CSEL_FREQ_W-1:0] freq_pick_d;
    logic [CSEL_REG_W-1:0]  sel_next_d;

    assign sel_next_d = sel_wr_en ? sel_wr_data : st_q.sel;

    clk_sel_field_decode #(
        .REG_W      (CSEL_REG_W),
        .FIELD_LSB  (FIELD_LSB),
        .FIELD_W    (FIELD_W),
        .NUM_INPUTS (NUM_INPUTS)
    ) i_decode (
        .reg_val  (sel_next_d),
        .use_idx  (use_idx_d),
        .bad_code (bad_code_d)
    );

    clk_sel_freq_mux #(
        .NUM_INPUTS (NUM_INPUTS),
        .FREQ_W     (CSEL_FREQ_W)
    ) i_mux (
        .freq_in  (freq_in),
        .idx      (use_idx_d),
        .freq_sel (freq_pick_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sel   = sel_next_d;
        st_d.freq  = freq_pick_d;
        st_d.fault = sel_wr_en & bad_code_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= RESET_SEL;
            st_q.freq  <= '0;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_out  = st_q.freq;
    assign sel_fault = st_q.fault;

    // Marks that the previous edge was already out of reset.
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(sel_wr_en)) |-> (st_q.sel == $past(st_q.sel)));

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel_wr_en)) |-> (st_q.sel == $past(sel_wr_data)));

    // R3
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sel_fault) |-> (freq_out == $past(freq_in[0])));

    // R4
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sel_fault) |-> $past(sel_wr_en));
endmodule

// File: tb/test_clk_src_select.sv
module test_clk_src_select;
    localparam int          N     = 5;
    localparam int          LSB   = 18;
    localparam int          W     = 3;
    localparam logic [31:0] RSEL  = 32'h0008_0000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic [N-1:0][63:0] fin;
    logic [63:0]        fout;
    logic               fault;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";

    logic [31:0] m_sel;
    logic [63:0] m_out = '0;
    logic        m_fault = 1'b0;

    always #4 clk = ~clk;

    clk_src_select #(
        .NUM_INPUTS (N),
        .FIELD_LSB  (LSB),
        .FIELD_W    (W),
        .RESET_SEL  (RSEL)
    ) i_clk_src_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_en   (wr_en),
        .sel_wr_data (wr_data),
        .freq_in     (fin),
        .freq_out    (fout),
        .sel_fault   (fault)
    );

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk) begin
        logic [31:0] nsel;
        int          k;
        if (!rst_n) begin
            m_sel   <= RSEL;
            m_out   <= '0;
            m_fault <= 1'b0;
        end else begin
            nsel = wr_en ? wr_data : m_sel;
            k    = int'((nsel >> LSB) & ((32'd1 << W) - 1));
            m_sel <= nsel;
            if (k >= N) begin
                m_out   <= fin[0];
                m_fault <= wr_en;
            end else begin
                m_out   <= fin[k];
                m_fault <= 1'b0;
            end
        end
    end

    task automatic step_check();
        @(negedge clk);
        n_vec++;
        if (fout !== m_out || fault !== m_fault) begin
            n_bad++;
            $display("FAIL %s: freq_out=%h sel_fault=%b expected freq_out=%h sel_fault=%b",
                     tag, fout, fault, m_out, m_fault);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step_check();
        wr_en   = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) fin[i] = 64'h0100_0000_0000_0000 * (i + 1) + 64'(i * 7 + 3);
        // R1: reset state
        tag = "R1";
        repeat (3) step_check();
        rst_n = 1'b1;
        step_check();   // first cycle after reset: input named by RESET_SEL
        step_check();
        // R2: every in-range code
        tag = "R2";
        for (int k = 0; k < N; k++) wr(32'(k) << LSB);
        // R3: every out-of-range code
        tag = "R3";
        for (int k = N; k < (1 << W); k++) wr(32'(k) << LSB);
        // R4: idle cycles holding an out-of-range code
        tag = "R4";
        repeat (3) step_check();
        // R6: input 0 change while out of range
        tag = "R6";
        fin[0] = 64'hDEAD_BEEF_0000_0001;
        step_check();
        step_check();
        // R5: bits outside the field
        tag = "R5";
        wr(~(32'(7) << LSB) | (32'(3) << LSB));
        wr(32'(3) << LSB);
        wr(32'hFFFF_FFFF & ~(32'(7) << LSB));
        // R6: selected input changes without write
        tag = "R6";
        wr(32'(4) << LSB);
        for (int j = 0; j < 4; j++) begin
            fin[4] = 64'h0000_0123_4567_0000 + 64'(j);
            step_check();
        end
        // R7: no write, non-selected inputs change
        tag = "R7";
        for (int j = 0; j < 4; j++) begin
            fin[1] = 64'(j) << 20;
            fin[2] = ~(64'(j));
            step_check();
        end
        // R3: random mix of writes and input changes
        tag = "R3";
        for (int j = 0; j < 400; j++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_data = $urandom;
            fin[$urandom % N] = {$urandom, $urandom};
            step_check();
        end
        wr_en = 1'b0;
        step_check();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule